// File: doc/BRIEF.md
# Reset Source Capture Controller

This block combines four reset causes into a set of synchronous reset outputs and keeps a record of what caused the most recent reset. The four causes are a power-on event, a watchdog expiry, an external reset pin and a request from software. The power-on, watchdog and pin events come from outside the block as single-cycle pulses that are synchronous to `clk`. A software request comes from a write on a small memory-mapped bus.

The cause record is a 4-bit flag set. It reads as an 8-bit value at offset 0x0, and its upper nibble is always zero. Other resets do not touch this record, so code that runs after a reset can find out why the reset happened. Flags are cleared through a separate write-only register at offset 0x4. Each trigger starts a pulse on the reset outputs, and the destinations reset depend on which source triggered. Pins, peripherals and memory-mapped registers are reset by every source. The watchdog timer is reset only by power-on. A `mem_valid` output reports whether memory contents survived the last reset.

The input `rst_n` is a synchronous active-low initialisation for bring-up. It sets every flop to zero.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the status reads 0x00, all four reset outputs are low and `mem_valid` is low.
- R2: Status bit 0 is power-on, bit 1 is watchdog, bit 2 is software and bit 3 is external. A read with `bus_sel`=1 at offset 0x0 returns the flags in bits 3:0, with bits 7:4 zero. A read at offset 0x4, a read at any other offset, or any cycle with `bus_sel`=0 returns 0x00.
- R3: A watchdog or external event pulse sets its own flag at the next clock edge and keeps the other flags.
- R4: A power-on event makes the status exactly 0x01 at the next edge. It overrides every other event or write in the same cycle.
- R5: A write to offset 0x0 with data bit 2 set sets the software flag and starts a reset. Every other data bit of that write has no effect. A write with data bit 2 clear changes nothing.
- R6: A write to offset 0x4 clears each flag whose data bit is 1 and keeps each flag whose data bit is 0. A hardware event in the same cycle wins over a clear of its own flag.
- R7: While the software flag is set, a write to offset 0x4 with data bit 2 clear starts a new software reset, and the flag stays set.
- R8: Every trigger drives `rst_pins`, `rst_periph` and `rst_mmr` high from the next edge for exactly STRETCH cycles (default 4), counted from the last trigger. A trigger during a pulse restarts the count.
- R9: `rst_wdt` is high only during a pulse that contains a power-on trigger, and is then high for the whole pulse.
- R10: After a power-on trigger `mem_valid` is low. After a trigger that includes no power-on, `mem_valid` is high.
- R11: A write to any offset other than 0x0 and 0x4 changes no flag and starts no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low bring-up initialisation |
| por_evt | input | 1 | Power-on event pulse |
| wdt_evt | input | 1 | Watchdog expiry pulse |
| ext_evt | input | 1 | External reset pin pulse (synchronised) |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and flags |
| rst_pins | output | 1 | Reset for external pins |
| rst_periph | output | 1 | Reset for peripherals |
| rst_mmr | output | 1 | Reset for memory-mapped registers |
| rst_wdt | output | 1 | Reset for the watchdog timer |
| mem_valid | output | 1 | Memory contents survived the last reset |

## Verification
The assertions assume that the event inputs are already synchronous to `clk`. They also assume that `rst_n` is used only to initialise the block and not as a reset cause. The watchdog-output check assumes that `rst_wdt` rises only in the cycle after a power-on trigger. The stimulus changes every input on the falling clock edge and holds each event high for one cycle. Bus offsets are drawn from the mapped pair and one unmapped offset, so no input is ever undefined when an edge samples it.

// File: rtl/rst_cause_pkg.sv
// Shared constants for the reset cause controller.
// Assumes flag bit positions equal the source indices used everywhere else.
package rst_cause_pkg;
    localparam int NUM_SRC  = 4;
    localparam int NUM_OUT  = 4;
    localparam int REG_W    = 8;

    // Source indices, also the status flag bit positions.
    localparam int SRC_POR  = 0;
    localparam int SRC_WDT  = 1;
    localparam int SRC_SW   = 2;
    localparam int SRC_EXT  = 3;

    // Reset output domains.
    localparam int OUT_PINS   = 0;
    localparam int OUT_PERIPH = 1;
    localparam int OUT_MMR    = 2;
    localparam int OUT_WDT    = 3;

    // Domains reset by a given source; only power-on reaches the watchdog.
    function automatic logic [NUM_OUT-1:0] src_domains(input int src);
        logic [NUM_OUT-1:0] m;
        m = '1;
        if (src != SRC_POR) m[OUT_WDT] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/rst_cause_regs.sv
// Cause flags and bus decode. Holds the 4-bit cause record, services status
// and clear writes, and reports which sources trigger in this cycle.
// Assumes event inputs are synchronous single-cycle pulses.
module rst_cause_regs
    import rst_cause_pkg::*;
#(
    parameter int               ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] STS_OFF = 'h0,
    parameter logic [ADDR_W-1:0] CLR_OFF = 'h4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_evt,
    input  logic                wdt_evt,
    input  logic                ext_evt,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_SRC-1:0]  wr_bits,
    output logic [REG_W-1:0]    rd_data,
    output logic [NUM_SRC-1:0]  trig
);

    logic               sts_wr;
    logic               clr_wr;
    logic               sw_req;
    logic [NUM_SRC-1:0] sts_q;
    logic [NUM_SRC-1:0] sts_d;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] set_mask;

    // Decode writes and the software request.
    always_comb begin
        sts_wr = bus_sel && bus_wr && (bus_addr == STS_OFF);
        clr_wr = bus_sel && bus_wr && (bus_addr == CLR_OFF);
        sw_req = (sts_wr && wr_bits[SRC_SW])
              || (clr_wr && sts_q[SRC_SW] && !wr_bits[SRC_SW]);
    end

    // Next flag value: power-on wins, otherwise sets win over clears.
    always_comb begin
        clr_mask          = clr_wr ? wr_bits : '0;
        set_mask          = '0;
        set_mask[SRC_WDT] = wdt_evt;
        set_mask[SRC_SW]  = sw_req;
        set_mask[SRC_EXT] = ext_evt;
        if (por_evt) begin
            sts_d          = '0;
            sts_d[SRC_POR] = 1'b1;
        end else begin
            sts_d = (sts_q & ~clr_mask) | set_mask;
        end
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    // Per-source trigger vector for the pulse stage.
    always_comb begin
        trig          = '0;
        trig[SRC_POR] = por_evt;
        trig[SRC_WDT] = wdt_evt;
        trig[SRC_SW]  = sw_req;
        trig[SRC_EXT] = ext_evt;
    end

    // Read path: flags at the status offset only, upper bits zero.
    always_comb begin
        rd_data = '0;
        if (bus_sel && !bus_wr && (bus_addr == STS_OFF))
            rd_data[NUM_SRC-1:0] = sts_q;
    end

    // R4: power-on leaves only its own flag.
    a_r4_por_exact: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> (sts_q == 4'b0001));

    // R6: a clear of the external flag with no competing set removes it.
    a_r6_clear_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wr_bits[SRC_EXT] && !ext_evt && !por_evt) |=> !sts_q[SRC_EXT]);

    // R7: a clear that spares the software flag keeps it set.
    a_r7_sw_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && sts_q[SRC_SW] && !wr_bits[SRC_SW] && !por_evt) |=> sts_q[SRC_SW]);

    // R3: a watchdog pulse without power-on sets its flag.
    a_r3_wdt_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_evt && !por_evt) |=> sts_q[SRC_WDT]);

endmodule

// File: rtl/rst_cause_stretch.sv
// Reset pulse stage. Turns trigger pulses into a pulse of STRETCH cycles on
// the domains named by the per-source table, and tracks memory validity.
// Assumes STRETCH >= 1; a trigger during a pulse restarts it.
module rst_cause_stretch
    import rst_cause_pkg::*;
#(
    parameter int STRETCH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  trig,
    output logic [NUM_OUT-1:0]  rst_out,
    output logic                mem_valid
);

    localparam int CNT_W = $clog2(STRETCH + 1);

    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_OUT-1:0] mask_q;
    logic [NUM_OUT-1:0] new_mask;
    logic [NUM_OUT-1:0] row [NUM_SRC];
    logic               active;
    logic               any_trig;

    // One table row per source, gated by its trigger.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_row
        assign row[s] = trig[s] ? src_domains(s) : '0;
    end

    // Merge the table rows of all triggering sources.
    always_comb begin
        new_mask = '0;
        for (int s = 0; s < NUM_SRC; s++) new_mask |= row[s];
        any_trig = |trig;
        active   = (cnt_q != '0);
    end

    // Pulse counter, domain mask and memory validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            mask_q    <= '0;
            mem_valid <= 1'b0;
        end else if (any_trig) begin
            cnt_q     <= CNT_W'(STRETCH);
            mask_q    <= (active ? mask_q : '0) | new_mask;
            mem_valid <= !trig[SRC_POR];
        end else if (active) begin
            cnt_q     <= cnt_q - CNT_W'(1);
        end
    end

    assign rst_out = active ? mask_q : '0;

    // Checker counter: cycles since the last trigger while a pulse runs.
    logic [CNT_W-1:0] len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        len_q <= '0;
        else if (any_trig) len_q <= '0;
        else if (active)   len_q <= len_q + CNT_W'(1);
    end

    // R8: a pulse ends exactly STRETCH cycles after its last trigger.
    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_out[OUT_MMR]) && !rst_out[OUT_MMR]) |-> (len_q == CNT_W'(STRETCH)));

    // R9: the watchdog reset only starts after a power-on trigger.
    a_r9_wdt_por_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out[OUT_WDT]) |-> $past(trig[SRC_POR]));

    // R10: memory is not valid after power-on.
    a_r10_por_mem: assert property (@(posedge clk) disable iff (!rst_n)
        trig[SRC_POR] |=> !mem_valid);

    // R10: memory stays valid after any other reset.
    a_r10_other_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig && !trig[SRC_POR]) |=> mem_valid);

endmodule

// File: rtl/rst_cause_ctrl.sv
// Top of the reset cause controller: flag register with bus access feeding
// the reset pulse stage. Assumes inputs are synchronous to clk.
module rst_cause_ctrl
    import rst_cause_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int STRETCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_evt,
    input  logic              wdt_evt,
    input  logic              ext_evt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              rst_pins,
    output logic              rst_periph,
    output logic              rst_mmr,
    output logic              rst_wdt,
    output logic              mem_valid
);

    logic [NUM_SRC-1:0] trig;
    logic [NUM_OUT-1:0] rst_out;
    logic               unused_wdata_hi;

    // Upper data bits carry nothing for this block.
    assign unused_wdata_hi = ^bus_wdata[REG_W-1:NUM_SRC];

    rst_cause_regs #(
        .ADDR_W  (ADDR_W),
        .STS_OFF (ADDR_W'(0)),
        .CLR_OFF (ADDR_W'(4))
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_evt  (por_evt),
        .wdt_evt  (wdt_evt),
        .ext_evt  (ext_evt),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_bits  (bus_wdata[NUM_SRC-1:0]),
        .rd_data  (bus_rdata),
        .trig     (trig)
    );

    rst_cause_stretch #(
        .STRETCH (STRETCH)
    ) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .rst_out   (rst_out),
        .mem_valid (mem_valid)
    );

    assign rst_pins   = rst_out[OUT_PINS];
    assign rst_periph = rst_out[OUT_PERIPH];
    assign rst_mmr    = rst_out[OUT_MMR];
    assign rst_wdt    = rst_out[OUT_WDT];

    // R5/R7: a software request from the flag stage reaches the register reset.
    a_r7_sw_reaches_mmr: assert property (@(posedge clk) disable iff (!rst_n)
        trig[SRC_SW] |=> rst_mmr);

endmodule

// File: tb/rst_cause_ctrl_tb.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb;
    localparam int STRETCH = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       por_evt, wdt_evt, ext_evt;
    logic       bus_sel, bus_wr;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       rst_pins, rst_periph, rst_mmr, rst_wdt, mem_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model of the requirements.
    logic [3:0] m_sts  = '0;
    int         m_cnt  = 0;
    logic [3:0] m_mask = '0;   // {wdt, mmr, periph, pins}
    logic       m_mv   = 1'b0;

    always #2 clk = ~clk;

    rst_cause_ctrl #(.ADDR_W(4), .STRETCH(STRETCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .wdt_evt(wdt_evt),
        .ext_evt(ext_evt), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_pins(rst_pins), .rst_periph(rst_periph), .rst_mmr(rst_mmr),
        .rst_wdt(rst_wdt), .mem_valid(mem_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic s, input logic w, input logic [3:0] a);
        return (s && !w && a == 4'h0) ? {4'b0, m_sts} : 8'h00;
    endfunction

    // Advance the model by one clock edge with the inputs now applied.
    function automatic void model_edge(input logic p, input logic wd, input logic ex,
                                       input logic s, input logic w,
                                       input logic [3:0] a, input logic [7:0] d);
        logic stsw, clrw, sw;
        logic [3:0] nm;
        stsw = s && w && a == 4'h0;
        clrw = s && w && a == 4'h4;
        sw   = (stsw && d[2]) || (clrw && m_sts[2] && !d[2]);
        if (p) m_sts = 4'b0001;
        else   m_sts = (m_sts & ~(clrw ? d[3:0] : 4'b0)) | {ex, sw, wd, 1'b0};
        nm = p ? 4'b1111 : 4'b0111;
        if (p || wd || ex || sw) begin
            m_mask = ((m_cnt != 0) ? m_mask : 4'b0) | nm;
            m_cnt  = STRETCH;
            m_mv   = !p;
        end else if (m_cnt != 0) begin
            m_cnt--;
        end
    endfunction

    task automatic step(input logic p, input logic wd, input logic ex,
                        input logic s, input logic w, input logic [3:0] a,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        por_evt = p; wdt_evt = wd; ext_evt = ex;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_edge(p, wd, ex, s, w, a, d);
        #1;
        chk(tag, bus_rdata, exp_rd(s, w, a));
        chk("R8 pins",   rst_pins,   (m_cnt != 0) && m_mask[0]);
        chk("R8 periph", rst_periph, (m_cnt != 0) && m_mask[1]);
        chk("R8 mmr",    rst_mmr,    (m_cnt != 0) && m_mask[2]);
        chk("R9 wdt",    rst_wdt,    (m_cnt != 0) && m_mask[3]);
        chk("R10 memv",  mem_valid,  m_mv);
    endtask

    task automatic rd_sts(input string tag);
        step(0, 0, 0, 1, 0, 4'h0, 8'h00, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) rd_sts(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        por_evt = 0; wdt_evt = 0; ext_evt = 0;
        bus_sel = 1; bus_wr = 0; bus_addr = 4'h0; bus_wdata = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        // R1: state while held in initialisation.
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 outs", {rst_pins, rst_periph, rst_mmr, rst_wdt, mem_valid}, 5'b0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // R4: power-on alone.
        step(1, 0, 0, 1, 0, 4'h0, 8'h00, "R4");
        idle(6, "R4");
        // R3: hardware sources set their own flag.
        step(0, 1, 0, 1, 0, 4'h0, 8'h00, "R3");
        idle(5, "R3");
        step(0, 0, 1, 1, 0, 4'h0, 8'h00, "R3");
        idle(5, "R3");
        // R5: status write without bit 2 changes nothing.
        step(0, 0, 0, 1, 1, 4'h0, 8'hFB, "R5");
        idle(2, "R5");
        // R2: clear offset and unmapped offset read as zero.
        step(0, 0, 0, 1, 0, 4'h4, 8'h00, "R2");
        step(0, 0, 0, 1, 0, 4'h8, 8'h00, "R2");
        step(0, 0, 0, 0, 0, 4'h0, 8'h00, "R2");
        // R6: clear external; clear watchdog while it fires again.
        step(0, 0, 0, 1, 1, 4'h4, 8'h08, "R6");
        rd_sts("R6");
        step(0, 1, 0, 1, 1, 4'h4, 8'h02, "R6");
        idle(5, "R6");
        step(0, 0, 0, 1, 1, 4'h4, 8'h03, "R6");
        rd_sts("R6");
        // R5: software reset through the status register.
        step(0, 0, 0, 1, 1, 4'h0, 8'hF4, "R5");
        idle(6, "R5");
        // R7: clear that spares bit 2 retriggers; clearing bit 2 does not.
        step(0, 0, 0, 1, 1, 4'h4, 8'h01, "R7");
        idle(2, "R7");
        step(0, 0, 0, 1, 1, 4'h4, 8'h00, "R7");
        idle(6, "R7");
        step(0, 0, 0, 1, 1, 4'h4, 8'h04, "R7");
        idle(6, "R7");
        // R11: writes to unmapped offsets.
        step(0, 0, 0, 1, 1, 4'h8, 8'hFF, "R11");
        step(0, 0, 0, 1, 1, 4'hC, 8'hFF, "R11");
        idle(3, "R11");
        // R4: power-on together with every other source and a software write.
        step(0, 1, 1, 1, 0, 4'h0, 8'h00, "R4");
        step(1, 1, 1, 1, 1, 4'h0, 8'h04, "R4");
        idle(7, "R4");

        // Constrained random phase.
        for (int i = 0; i < 3000; i++) begin
            logic p, wd, ex, s, w;
            logic [3:0] a;
            logic [7:0] d;
            p  = ($urandom % 64) == 0;
            wd = ($urandom % 24) == 0;
            ex = ($urandom % 24) == 0;
            s  = ($urandom % 2) == 0;
            w  = ($urandom % 4) == 0;
            case ($urandom % 3)
                0:       a = 4'h0;
                1:       a = 4'h4;
                default: a = 4'h8;
            endcase
            d = 8'($urandom);
            step(p, wd, ex, s, w, a, d, "R6 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule